// File: doc/BRIEF.md
# Half-Duplex SPI Command Slave

This block is an SPI slave that lives entirely in the system clock domain. It samples the serial clock, chip select and MOSI through synchronizers and finds serial clock edges in the system domain. An external master reaches two stores by command: a 32-bit status word and a 64-byte data buffer. The buffer is organised as sixteen 32-bit words. Every transaction carries one command byte, then one address byte, then any number of data bytes, all most-significant bit first.

The local side of the chip sees the same storage through a simple register port. It can write buffer words and a second, locally owned status word. It can read back every word, including the status word that the master writes. A one-cycle completion strobe marks the end of each transaction. The incoming serial clock must run at no more than one eighth of the system clock.

Top module: `spi_cmd_slave`

## Requirements
- R1: Parameter SPI_MODE selects mode 0 (serial clock idles low) or mode 3 (idles high). In both modes MOSI is sampled on rising serial clock edges, MSB first, and MISO changes only after falling edges, so each returned bit is stable before the rising edge that samples it.
- R2: A transaction is framed by chip select low. The first 8 bits are the command, the next 8 bits are the address, and every following 8 bits form one data byte.
- R3: Command 0x01 writes data byte k into byte (k mod 4) of the master status word. Byte 0 is bits 7:0. The address byte is ignored.
- R4: Command 0x02 writes data byte k into buffer byte (A + k) mod 64, where A is the address byte. Buffer byte n is bits 8*(n mod 4)+7 down to 8*(n mod 4) of word n/4.
- R5: Command 0x03 returns buffer byte (A + k) mod 64 as data byte k on MISO, wrapping past byte 63 to byte 0.
- R6: Command 0x04 returns status byte (k mod 4) as data byte k. The status word comes from the master-written status when stat_sel is 0, and from the locally written status when stat_sel is 1.
- R7: Command 0x06 stores data byte k at buffer byte (A + k) mod 64 and returns the value that byte held before the store.
- R8: Any other command code drives MISO 0 for the whole transaction and modifies neither the buffer nor the master status.
- R9: Chip select rising mid-transaction discards the partial byte and resets the framing. Bytes completed earlier stay stored, and the next transaction starts with a command byte.
- R10: MISO is 0 while chip select is high and during the command and address bytes.
- R11: done is high for exactly one system clock cycle per transaction, a few cycles after chip select returns high.
- R12: On the register port, addresses 0 to 15 are buffer words, 16 is the local status word and 17 is the master status word. Other addresses read 0. Writes reach addresses 0 to 16, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| done | output | 1 | One-cycle end-of-transaction strobe |
| stat_sel | input | 1 | Status source for command 0x04 (0 master, 1 local) |
| loc_we | input | 1 | Register port write enable |
| loc_addr | input | 5 | Register port word address |
| loc_wdata | input | 32 | Register port write data |
| loc_rdata | output | 32 | Register port read data |

## Verification
A framing counter that slips by one bit shifts every returned byte. Such a fault appears at MISO within the first data byte and in the stored words read back over the register port right after the transaction. A wrong pointer or lane shows as a misplaced byte in the word read after a write, or as a wrong byte when the wrap at offset 64 is crossed. A stale framing state after an aborted transaction shows in the following transaction, because its command is then decoded from the wrong bits. Both serial clock modes receive identical stimulus, so a mode-specific output slip shows as a difference on one instance only.

// File: rtl/spi_cmd_slave_pkg.sv
package spi_cmd_slave_pkg;

    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_BUF_WR  = 8'h02;
    localparam logic [7:0] OP_BUF_RD  = 8'h03;
    localparam logic [7:0] OP_STAT_RD = 8'h04;
    localparam logic [7:0] OP_BUF_XCH = 8'h06;

    typedef enum logic [1:0] {
        FR_CMD  = 2'd0,
        FR_ADDR = 2'd1,
        FR_DATA = 2'd2
    } frame_t;

    typedef struct packed {
        logic buf_wr;
        logic stat_wr;
        logic buf_rd;
        logic stat_rd;
    } op_dec_t;

    typedef struct packed {
        logic       en;
        logic       to_stat;
        logic [7:0] idx;
        logic [7:0] data;
    } byte_wr_t;

    function automatic op_dec_t decode_op(input logic [7:0] op);
        op_dec_t d;
        d.buf_wr  = (op == OP_BUF_WR) || (op == OP_BUF_XCH);
        d.stat_wr = (op == OP_STAT_WR);
        d.buf_rd  = (op == OP_BUF_RD) || (op == OP_BUF_XCH);
        d.stat_rd = (op == OP_STAT_RD);
        return d;
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_slave_pkg::*;
#(
    parameter logic CPOL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_s,
    input  logic     cs_n_s,
    input  logic     mosi_s,
    input  logic [7:0] buf_byte_i,
    input  logic [7:0] stat_byte_i,
    output logic [7:0] buf_idx_o,
    output logic [7:0] stat_idx_o,
    output byte_wr_t wr_o,
    output logic     miso_o,
    output logic     done_o
);
    logic       sck_q;
    logic       cs_q;
    frame_t     frame;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] op_q;
    logic [7:0] addr_q;
    logic [7:0] dcnt;
    logic [7:0] tx_sh;
    logic       seen_rise;

    logic       sck_rise;
    logic       sck_fall;
    logic       cs_idle;
    logic [7:0] rx_byte;
    logic       byte_end;
    op_dec_t    dec;
    logic [7:0] tx_next;

    assign cs_idle  = cs_n_s;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign rx_byte  = {rx_sh, mosi_s};
    assign byte_end = sck_rise && (bit_cnt == 3'd7) && !cs_idle;
    assign dec      = decode_op(op_q);

    assign buf_idx_o  = addr_q + dcnt;
    assign stat_idx_o = dcnt;

    always_comb begin
        tx_next = 8'h00;
        if (frame == FR_DATA) begin
            if (dec.buf_rd)       tx_next = buf_byte_i;
            else if (dec.stat_rd) tx_next = stat_byte_i;
        end
    end

    always_comb begin
        wr_o.en      = byte_end && (frame == FR_DATA) && (dec.buf_wr || dec.stat_wr);
        wr_o.to_stat = dec.stat_wr;
        wr_o.idx     = addr_q + dcnt;
        wr_o.data    = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= CPOL;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    assign done_o = cs_n_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst || cs_idle) begin
            frame     <= FR_CMD;
            bit_cnt   <= 3'd0;
            rx_sh     <= 7'd0;
            op_q      <= 8'h00;
            addr_q    <= 8'h00;
            dcnt      <= 8'h00;
            tx_sh     <= 8'h00;
            seen_rise <= 1'b0;
        end else if (sck_rise) begin
            seen_rise <= 1'b1;
            bit_cnt   <= bit_cnt + 3'd1;
            rx_sh     <= rx_byte[6:0];
            if (bit_cnt == 3'd7) begin
                unique case (frame)
                    FR_CMD: begin
                        op_q  <= rx_byte;
                        frame <= FR_ADDR;
                    end
                    FR_ADDR: begin
                        addr_q <= rx_byte;
                        frame  <= FR_DATA;
                    end
                    default: dcnt <= dcnt + 8'd1;
                endcase
            end
        end else if (sck_fall && seen_rise) begin
            if (bit_cnt == 3'd0) tx_sh <= tx_next;
            else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign miso_o = tx_sh[7];

    // R10
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !miso_o);

    // R8
    unk_miso_chk: assert property (@(posedge clk) disable iff (rst)
        (frame == FR_DATA && !dec.buf_rd && !dec.stat_rd) |-> !miso_o);

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sck_rise && !cs_idle) |=> $stable(bit_cnt));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/spi_cmd_store.sv
module spi_cmd_store
    import spi_cmd_slave_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    parameter int LOC_AW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_wr_t          wr_i,
    input  logic [7:0]        buf_idx_i,
    input  logic [7:0]        stat_idx_i,
    input  logic              stat_sel_i,
    output logic [7:0]        buf_byte_o,
    output logic [7:0]        stat_byte_o,
    input  logic              loc_we_i,
    input  logic [LOC_AW-1:0] loc_addr_i,
    input  logic [31:0]       loc_wdata_i,
    output logic [31:0]       loc_rdata_o
);
    localparam int WIDX  = $clog2(BUF_WORDS);
    localparam int PTR_W = WIDX + 2;
    localparam logic [LOC_AW-1:0] A_LSTAT = LOC_AW'(BUF_WORDS);
    localparam logic [LOC_AW-1:0] A_MSTAT = LOC_AW'(BUF_WORDS + 1);

    logic [31:0] mem [BUF_WORDS];
    logic [31:0] m_stat;
    logic [31:0] l_stat;

    logic            loc_is_buf;
    logic [WIDX-1:0] loc_w;
    logic [WIDX-1:0] spi_w;
    logic [1:0]      spi_lane;
    logic [WIDX-1:0] rd_w;
    logic [1:0]      rd_lane;
    logic [31:0]     stat_word;
    logic            unused_bits;

    assign loc_is_buf = (loc_addr_i[LOC_AW-1:WIDX] == '0);
    assign loc_w      = loc_addr_i[WIDX-1:0];
    assign spi_w      = wr_i.idx[PTR_W-1:2];
    assign spi_lane   = wr_i.idx[1:0];
    assign rd_w       = buf_idx_i[PTR_W-1:2];
    assign rd_lane    = buf_idx_i[1:0];
    assign unused_bits = ^{wr_i.idx[7:PTR_W], buf_idx_i[7:PTR_W], stat_idx_i[7:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_WORDS; i++) mem[i] <= 32'h0;
            m_stat <= 32'h0;
            l_stat <= 32'h0;
        end else begin
            if (loc_we_i && loc_is_buf)        mem[loc_w] <= loc_wdata_i;
            if (loc_we_i && loc_addr_i == A_LSTAT) l_stat <= loc_wdata_i;
            // serial byte write is issued last, so it wins over a local word write
            if (wr_i.en && !wr_i.to_stat)      mem[spi_w][{spi_lane, 3'b000} +: 8] <= wr_i.data;
            if (wr_i.en && wr_i.to_stat)       m_stat[{stat_idx_i[1:0], 3'b000} +: 8] <= wr_i.data;
        end
    end

    assign stat_word   = stat_sel_i ? l_stat : m_stat;
    assign stat_byte_o = stat_word[{stat_idx_i[1:0], 3'b000} +: 8];
    assign buf_byte_o  = mem[rd_w][{rd_lane, 3'b000} +: 8];

    always_comb begin
        if (loc_is_buf)                  loc_rdata_o = mem[loc_w];
        else if (loc_addr_i == A_LSTAT)  loc_rdata_o = l_stat;
        else if (loc_addr_i == A_MSTAT)  loc_rdata_o = m_stat;
        else                             loc_rdata_o = 32'h0;
    end

    // R3
    mstat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_i.en && wr_i.to_stat) |=> $stable(m_stat));

    // R12
    lstat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(loc_we_i && loc_addr_i == A_LSTAT) |=> $stable(l_stat));
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_slave_pkg::*;
#(
    parameter int SPI_MODE  = 0,
    parameter int BUF_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sck,
    input  logic                         cs_n,
    input  logic                         mosi,
    output logic                         miso,
    output logic                         done,
    input  logic                         stat_sel,
    input  logic                         loc_we,
    input  logic [$clog2(BUF_WORDS):0]   loc_addr,
    input  logic [31:0]                  loc_wdata,
    output logic [31:0]                  loc_rdata
);
    localparam logic CPOL   = (SPI_MODE == 3);
    localparam int   LOC_AW = $clog2(BUF_WORDS) + 1;

    logic [2:0] pins_s;
    logic [7:0] buf_idx;
    logic [7:0] stat_idx;
    logic [7:0] buf_byte;
    logic [7:0] stat_byte;
    byte_wr_t   wr;

    spi_cmd_sync #(.W(3), .RST_VAL({CPOL, 1'b1, 1'b0})) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, cs_n, mosi}),
        .q   (pins_s)
    );

    spi_cmd_engine #(.CPOL(CPOL)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .sck_s       (pins_s[2]),
        .cs_n_s      (pins_s[1]),
        .mosi_s      (pins_s[0]),
        .buf_byte_i  (buf_byte),
        .stat_byte_i (stat_byte),
        .buf_idx_o   (buf_idx),
        .stat_idx_o  (stat_idx),
        .wr_o        (wr),
        .miso_o      (miso),
        .done_o      (done)
    );

    spi_cmd_store #(.BUF_WORDS(BUF_WORDS), .LOC_AW(LOC_AW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr),
        .buf_idx_i   (buf_idx),
        .stat_idx_i  (stat_idx),
        .stat_sel_i  (stat_sel),
        .buf_byte_o  (buf_byte),
        .stat_byte_o (stat_byte),
        .loc_we_i    (loc_we),
        .loc_addr_i  (loc_addr),
        .loc_wdata_i (loc_wdata),
        .loc_rdata_o (loc_rdata)
    );
endmodule

// File: tb/spi_cmd_slave_test.sv
`timescale 1ns/1ps
module spi_cmd_slave_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic sck0 = 1'b0, sck3 = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic stat_sel = 1'b0, loc_we = 1'b0;
    logic [4:0]  loc_addr = 5'd0;
    logic [31:0] loc_wdata = 32'h0;
    logic miso0, miso3, done0, done3;
    logic [31:0] rdata0, rdata3;

    spi_cmd_slave #(.SPI_MODE(0)) uut (
        .clk(clk), .rst(rst), .sck(sck0), .cs_n(cs_n), .mosi(mosi), .miso(miso0),
        .done(done0), .stat_sel(stat_sel), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(rdata0));

    spi_cmd_slave #(.SPI_MODE(3)) uut3 (
        .clk(clk), .rst(rst), .sck(sck3), .cs_n(cs_n), .mosi(mosi), .miso(miso3),
        .done(done3), .stat_sel(stat_sel), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(rdata3));

    int checks = 0, fails = 0, ntr = 0;
    int done_cnt0 = 0, done_cnt3 = 0;
    logic [7:0] txb  [0:79];
    logic [7:0] rxb0 [0:79];
    logic [7:0] rxb3 [0:79];
    logic [7:0] eb   [0:63];
    logic [31:0] ems = 32'h0, els = 32'h0;

    always @(posedge clk) begin
        if (!rst) begin
            if (done0) done_cnt0++;
            if (done3) done_cnt3++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic loc_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        loc_we = 1'b1; loc_addr = 5'(a); loc_wdata = d;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic loc_chk(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        loc_addr = 5'(a);
        #1;
        chk({tag, " mode0"}, rdata0, exp);
        chk({tag, " mode3"}, rdata3, exp);
    endtask

    function automatic logic [31:0] eword(input int w);
        return {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
    endfunction

    task automatic all_words(input string tag);
        for (int w = 0; w < 16; w++) loc_chk(tag, w, eword(w));
        loc_chk(tag, 17, ems);
    endtask

    // nbytes including command and address; cut > 0 aborts after that many bits
    task automatic xfer(input int nbytes, input int cut);
        int total;
        total = (cut > 0) ? cut : nbytes * 8;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int b = 0; b < total; b++) begin
            mosi = txb[b/8][7 - b%8];
            sck0 = 1'b0; sck3 = 1'b0;
            repeat (H) @(negedge clk);
            rxb0[b/8][7 - b%8] = miso0;
            rxb3[b/8][7 - b%8] = miso3;
            sck0 = 1'b1; sck3 = 1'b1;
            repeat (H) @(negedge clk);
        end
        sck0 = 1'b0; sck3 = 1'b1;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*H) @(negedge clk);
        ntr++;
        // R11 one strobe cycle per transaction
        chk("R11 done count mode0", done_cnt0, ntr);
        chk("R11 done count mode3", done_cnt3, ntr);
        // R10 idle and header bytes return zero
        chk("R10 miso idle mode0", {31'h0, miso0}, 32'h0);
        chk("R10 miso idle mode3", {31'h0, miso3}, 32'h0);
        if (total >= 16) begin
            chk("R10 header rx mode0", {rxb0[0], rxb0[1]}, 32'h0);
            chk("R10 header rx mode3", {rxb3[0], rxb3[1]}, 32'h0);
        end
    endtask

    task automatic rx_chk(input string tag, input int k, input logic [7:0] exp);
        chk({tag, " mode0"}, rxb0[2+k], exp);
        chk({tag, " mode3"}, rxb3[2+k], exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] unk [0:4];
        unk[0] = 8'h00; unk[1] = 8'h05; unk[2] = 8'h07; unk[3] = 8'h83; unk[4] = 8'hFF;
        for (int i = 0; i < 64; i++) eb[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R1, R10, R11)
        chk("R10 reset miso mode0", {31'h0, miso0}, 32'h0);
        chk("R1 reset miso mode3", {31'h0, miso3}, 32'h0);
        chk("R11 reset done", {30'h0, done0, done3}, 32'h0);
        loc_chk("R12 reset word0", 0, 32'h0);

        // R12 local writes and readback
        for (int i = 0; i < 64; i++) eb[i] = 8'((i * 37 + 5) & 8'hFF);
        for (int w = 0; w < 16; w++) loc_wr(w, eword(w));
        els = 32'hA5C3_0F1E;
        loc_wr(16, els);
        loc_wr(20, 32'hDEAD_BEEF);
        all_words("R12 readback");
        loc_chk("R12 lstat", 16, els);
        loc_chk("R12 unmapped", 31, 32'h0);
        loc_chk("R12 unmapped write", 20, 32'h0);

        // R5 full read with wrap, R1 both modes
        txb[0] = 8'h03; txb[1] = 8'h00;
        xfer(2 + 66, 0);
        for (int k = 0; k < 66; k++) rx_chk("R5 read wrap", k, eb[k % 64]);
        txb[1] = 8'hC5;
        xfer(2 + 3, 0);
        for (int k = 0; k < 3; k++) rx_chk("R5 read high addr", k, eb[(8'hC5 + k) % 64]);

        // R4 write crossing the wrap
        txb[0] = 8'h02; txb[1] = 8'd60;
        for (int k = 0; k < 8; k++) txb[2+k] = 8'(8'h90 + k);
        xfer(2 + 8, 0);
        for (int k = 0; k < 8; k++) eb[(60 + k) % 64] = 8'(8'h90 + k);
        all_words("R4 write wrap");

        // R7 exchange returns old contents
        txb[0] = 8'h06; txb[1] = 8'd10;
        for (int k = 0; k < 5; k++) txb[2+k] = 8'(8'h40 + k);
        xfer(2 + 5, 0);
        for (int k = 0; k < 5; k++) rx_chk("R7 exchange old", k, eb[10 + k]);
        for (int k = 0; k < 5; k++) eb[10 + k] = 8'(8'h40 + k);
        all_words("R7 exchange store");

        // R3 status write, address ignored
        txb[0] = 8'h01; txb[1] = 8'h33;
        for (int k = 0; k < 6; k++) txb[2+k] = 8'(8'hD0 + k);
        xfer(2 + 6, 0);
        for (int k = 0; k < 6; k++) ems[8*(k%4) +: 8] = 8'(8'hD0 + k);
        all_words("R3 status write");

        // R6 status read from both sources
        txb[0] = 8'h04; txb[1] = 8'h00;
        for (int k = 0; k < 6; k++) txb[2+k] = 8'h00;
        stat_sel = 1'b0;
        xfer(2 + 6, 0);
        for (int k = 0; k < 6; k++) rx_chk("R6 master status", k, ems[8*(k%4) +: 8]);
        stat_sel = 1'b1;
        xfer(2 + 6, 0);
        for (int k = 0; k < 6; k++) rx_chk("R6 local status", k, els[8*(k%4) +: 8]);
        stat_sel = 1'b0;

        // R8 unknown commands
        for (int u = 0; u < 5; u++) begin
            txb[0] = unk[u]; txb[1] = 8'h04;
            for (int k = 0; k < 4; k++) txb[2+k] = 8'hEE;
            xfer(2 + 4, 0);
            for (int k = 0; k < 4; k++) rx_chk("R8 unknown miso", k, 8'h00);
        end
        all_words("R8 unknown no write");

        // R9 abort mid byte
        txb[0] = 8'h02; txb[1] = 8'd20; txb[2] = 8'h5A; txb[3] = 8'hC3;
        xfer(4, 8*3 + 3);
        eb[20] = 8'h5A;
        all_words("R9 abort partial");
        txb[0] = 8'h03; txb[1] = 8'd20; txb[2] = 8'h00; txb[3] = 8'h00;
        xfer(4, 0);
        rx_chk("R9 after abort", 0, eb[20]);
        rx_chk("R9 after abort", 1, eb[21]);

        // R2 framing: command byte after a transaction of header only
        txb[0] = 8'h02; txb[1] = 8'd0;
        xfer(2, 0);
        all_words("R2 header only");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule